// File: doc/BRIEF.md
# Free-Running Capture/Compare Timer

This block is a free-running up-counter with a set of channels that share it. Each channel is set to one of two roles. As a compare channel it holds a value D and, once the counter passes through D + 1, it pulses its interrupt line for one clock and inverts its output pin. As a capture channel it watches an asynchronous input pin. The pin passes through a synchronizer, and on a chosen edge the channel stores the counter value and pulses its interrupt line.

Software drives the timer through a small word-wide register port. A write takes effect on the clock edge where the write strobe is high. A read is registered, so data appears one cycle after the address. Software can start and stop the counter, and a stopped counter holds zero. It can read the live count at any time and pick each channel's role and capture edge. A sticky flag records each wrap of the counter.

Top module: `cc_timer`

## Requirements
- R1: After reset the count, the run bit, the overflow flag, the mode register, every channel value, every output pin and every interrupt line are all 0.
- R2: Bit 0 of address 0 is the run bit. While it is 1 the count rises by one every clock. After it is written 0, the count reads 0 and stays 0.
- R3: A read returns, one clock after the address is presented, the following data. Address 0 gives {overflow in bit 1, run in bit 0}. Address 1 gives the mode register. Address 2 gives the live count. Addresses 4 to 7 give channel values 0 to 3.
- R4: The overflow flag is bit 1 of address 0. It is set on the clock where the count wraps from all ones to 0, and it stays set. Writing address 0 with bit 1 at 0 clears it, and writing bit 1 as 1 never sets it. When a clearing write lands on the same clock as a wrap, the flag ends up set.
- R5: A compare channel holding value D raises its interrupt line for exactly one clock, and inverts its output pin, in the cycle after the count equals D + 1.
- R6: Mode bit i (address 1) set to 1 makes channel i a capture channel. A qualifying pin edge passes two synchronizer stages. On the third clock after the pin changes, the channel stores the count held before that clock and pulses its interrupt line.
- R7: Mode bits [5+2i:4+2i] select channel i's capture edge: 00 no edge, 01 rising, 10 falling, 11 both. An edge that is not selected leaves the channel value and the interrupt line unchanged.
- R8: Mode bit i at 0 makes channel i a compare channel. A compare channel ignores its input pin, and a written channel value holds until it is written again.
- R9: A compare value of all ones matches when the count is 0. This covers the first cycle after the counter starts and every wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| cap_in | input | 4 | Asynchronous capture input pins, one per channel |
| cmp_out | output | 4 | Compare output pins, one per channel |
| irq | output | 4 | One-clock interrupt pulses, one per channel |

## Verification
Two functions can meet on the same clock: the counter's wrap sets the overflow flag, and a software write to the control register asks to clear it. The bench starts the counter at a known cycle and counts clocks itself. It then times the write so that its strobe lands on the very edge where the count goes from all ones to 0, and it expects the flag to read back as set. A second write afterwards must clear the flag.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int REG_CTRL  = 0;
  localparam int REG_MODE  = 1;
  localparam int REG_COUNT = 2;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ctrl_we,
  input  logic         run_wr,
  input  logic         ovf_wr,
  output logic [W-1:0] count,
  output logic         run,
  output logic         ovf
);
  logic wrap;
  assign wrap = run && (count == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      run   <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      if (ctrl_we) run <= run_wr;
      count <= run ? count + W'(1) : '0;
      if (wrap) ovf <= 1'b1;
      else if (ctrl_we && !ovf_wr) ovf <= 1'b0;
    end
  end

  // R2
  cnt_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (count == '0));
  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (run && count == '1) |=> (ovf && count == '0));
  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !(ctrl_we && !ovf_wr)) |=> ovf);
endmodule

// File: rtl/cct_edge_det.sv
module cct_edge_det
  import cct_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       hit
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
  assign fall = ~sync_q[STAGES-1] & last_q;

  always_comb begin
    case (sel)
      EDGE_NONE: hit = 1'b0;
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      default:   hit = rise | fall;
    endcase
  end
endmodule

// File: rtl/cct_channel.sv
module cct_channel #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] count,
  input  logic         cap_mode,
  input  logic [1:0]   edge_sel,
  input  logic         pin,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] value,
  output logic         irq,
  output logic         tout
);
  logic edge_hit, cap_hit, cmp_hit;

  cct_edge_det #(.STAGES(STAGES)) u_edge (
    .clk(clk), .rst(rst), .pin(pin), .sel(edge_sel), .hit(edge_hit)
  );

  assign cap_hit = cap_mode && edge_hit;
  assign cmp_hit = run && !cap_mode && (count == value + W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      irq   <= 1'b0;
      tout  <= 1'b0;
    end else begin
      if (cap_hit)    value <= count;
      else if (wr_en) value <= wr_data;
      irq  <= cap_hit | cmp_hit;
      tout <= tout ^ cmp_hit;
    end
  end

  // R5
  tout_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(tout) |-> irq);
  // R7
  no_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_mode && edge_sel == 2'b00) |=> !irq);
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(2 * NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic [NCH-1:0]   cap_in,
  output logic [NCH-1:0]   cmp_out,
  output logic [NCH-1:0]   irq
);
  localparam int MODE_W = 3 * NCH;

  logic [CNT_W-1:0]  count;
  logic              run, ovf;
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  ch_val [NCH];
  logic [CNT_W-1:0]  rd_next;

  cct_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .ctrl_we(bus_we && bus_addr == AW'(REG_CTRL)),
    .run_wr(bus_wdata[0]), .ovf_wr(bus_wdata[1]),
    .count(count), .run(run), .ovf(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (bus_we && bus_addr == AW'(REG_MODE)) mode_q <= MODE_W'(bus_wdata);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cct_channel #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_ch (
      .clk(clk), .rst(rst), .run(run), .count(count),
      .cap_mode(mode_q[i]),
      .edge_sel(mode_q[NCH + 2*i +: 2]),
      .pin(cap_in[i]),
      .wr_en(bus_we && bus_addr == AW'(NCH + i)),
      .wr_data(bus_wdata),
      .value(ch_val[i]), .irq(irq[i]), .tout(cmp_out[i])
    );
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == AW'(REG_CTRL))  rd_next = CNT_W'({ovf, run});
    if (bus_addr == AW'(REG_MODE))  rd_next = CNT_W'(mode_q);
    if (bus_addr == AW'(REG_COUNT)) rd_next = count;
    for (int i = 0; i < NCH; i++)
      if (bus_addr == AW'(NCH + i)) rd_next = ch_val[i];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R3
  rd_count_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == AW'(REG_COUNT)) |=> (bus_rdata == $past(count)));
endmodule

// File: tb/tb_cc_timer.sv
`timescale 1ns/1ps
module tb_cc_timer;
  localparam int W = 16, N = 4, AW = 3;
  localparam int A_CTRL = 0, A_MODE = 1, A_CNT = 2, A_CC = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic we = 1'b0;
  logic [W-1:0] wdata = '0, rdata;
  logic [N-1:0] cap = '0, tout, irq;

  always #5 clk = ~clk;

  cc_timer dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .cap_in(cap), .cmp_out(tout), .irq(irq)
  );

  int checks = 0, errors = 0, t = 0, t0 = 0;

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); t++; end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0d)", req, act, exp, t);
    end
  endtask

  task automatic wr(int a, int d);
    addr = AW'(a); wdata = W'(d); we = 1'b1;
    step();
    we = 1'b0;
  endtask

  task automatic rd(int a, output logic [W-1:0] v);
    addr = AW'(a);
    step();
    v = rdata;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    step(3);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 cmp_out", tout, 0);
    rd(A_CNT, v);  check("R1 count", v, 0);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_MODE, v); check("R1 mode", v, 0);
    rd(A_CC, v);   check("R1 cc0", v, 0);

    // channels 0,1 compare (D=100, D=all ones); 2 capture rising; 3 capture both
    wr(A_CC + 0, 100);
    wr(A_CC + 1, 16'hFFFF);
    wr(A_MODE, 16'h0DFC);
    rd(A_CC + 0, v); check("R8 cc0 written", v, 100);
    rd(A_MODE, v);   check("R3 mode readback", v, 16'h0DFC);

    wr(A_CTRL, 1);
    t0 = t;
    for (int i = 0; i < 300; i++) begin
      int r;
      r = t - t0;
      check("R5 irq0", irq[0], r == 102);
      check("R5 cmp_out0", tout[0], r >= 102);
      check("R9 irq1", irq[1], r == 1);
      check("R9 cmp_out1", tout[1], r >= 1);
      check("R6 irq2", irq[2], r == 23);
      check("R7 irq3 both edges", irq[3], r == 23 || r == 53);
      if (r == 20) cap[3:2] = 2'b11;
      if (r == 50) cap[3:2] = 2'b00;
      if (r == 30) cap[1:0] = 2'b11;
      if (r == 60) cap[1:0] = 2'b00;
      step();
    end
    rd(A_CC + 0, v); check("R8 cc0 ignores pin", v, 100);
    rd(A_CC + 2, v); check("R6 cc2 captured", v, 22);
    rd(A_CC + 3, v); check("R7 cc3 falling capture", v, 52);
    rd(A_CNT, v);    check("R3 count live", v, W'(t - 1 - t0));
    rd(A_CNT, v);    check("R2 count advances", v, W'(t - 1 - t0));

    // R2 stop returns count to zero
    wr(A_CTRL, 0);
    step();
    rd(A_CNT, v); check("R2 stopped count", v, 0);
    step(5);
    rd(A_CNT, v); check("R2 stays zero", v, 0);

    // R7 ch2 falling only, ch3 none
    wr(A_MODE, 16'h02FC);
    cap[3:2] = 2'b11;
    for (int i = 0; i < 5; i++) begin
      step();
      check("R7 rise ignored", irq[3:2], 0);
    end
    cap[3:2] = 2'b00;
    step(2);
    check("R6 sync delay", irq[3:2], 0);
    step();
    check("R7 falling only", irq[3:2], 2'b01);
    step();
    check("R5 one-cycle pulse", irq, 0);
    rd(A_CC + 2, v); check("R7 cc2 falling capture", v, 0);
    rd(A_CC + 3, v); check("R7 cc3 unchanged", v, 52);

    // R4 overflow with same-cycle clear
    wr(A_CTRL, 3);
    t0 = t;
    rd(A_CTRL, v); check("R4 write 1 does not set", v, 1);
    step(t0 + 65535 - t);
    wr(A_CTRL, 1);
    step();
    check("R9 match at wrap", irq[1], 1);
    rd(A_CTRL, v); check("R4 set wins over clear", v, 3);
    rd(A_CNT, v);  check("R3 count after wrap", v, W'(t - 1 - t0));
    step(3);
    rd(A_CTRL, v); check("R4 sticky", v, 3);
    wr(A_CTRL, 1);
    rd(A_CTRL, v); check("R4 cleared", v, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule